// File: doc/BRIEF.md
# Multicycle Instruction Phase Sequencer

This block is a compact 16-bit processor core. Each instruction passes through a chain of named phases: a fetch built from explicit register transfers (address register, data register, instruction register, then a program counter bump), a decode step, and then only the later phases that the opcode needs. These are effective-address evaluation, operand fetch, execute and result store. The core has eight general registers and one shared adder. It talks to a word-addressed synchronous memory that returns read data one clock after the address is presented.

Three opcodes do real work: a register-to-register add, a load from a base register plus a zero-extended 6-bit offset, and an unconditional jump to the address held in a register. Every other opcode decodes as a no-op and returns to fetch. A run input acts as a global clock enable. While it is low, every state element holds, so the machine can be frozen at any phase and resumed without losing a step. The current phase code and the program counter are visible on ports for integration and debug.

Top module: `phase_core`

## Requirements
- R1: After reset the phase is 0, `pc` is 0, `mem_we` is 0, and all eight general registers read as zero.
- R2: Fetch runs as phases 0 to 4. Phase 0 copies the program counter into the memory address register. Phase 1 presents it on `mem_addr` so the memory can read it. Phase 2 captures `mem_rdata` into the data register. Phase 3 moves that word into the instruction register. Phase 4 adds one to the program counter.
- R3: Phase codes are 0..4 fetch steps, 5 decode, 6 address evaluation, 7 operand read wait, 8 operand capture, 9 execute, 10 store. Decode (5) always follows fetch step 4.
- R4: Opcode 0001 in bits 15:12 adds the registers selected by bits 8:6 and bits 2:0, modulo 2^16, and writes the sum to the register selected by bits 11:9. Its phases are 0-5, 8, 9, 10, so address evaluation is skipped.
- R5: Opcode 0110 loads the memory word at (register selected by bits 8:6) + zero-extended bits 5:0, modulo 2^16, into the register selected by bits 11:9. That address appears on `mem_addr` in phase 7. Its phases are 0-5, 6, 7, 8, 10, so execute is skipped.
- R6: Opcode 0100 writes the register selected by bits 8:6 into the program counter during execute. Its phases are 0-5, 8, 9, and the next fetch reads from that address.
- R7: Any other opcode runs phases 0-5, advances the program counter by one and changes no general register.
- R8: While `run` is low, the phase, program counter, memory address and all registers hold their values. When `run` returns high, the sequence resumes from the held phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High lets the machine step, low freezes it |
| mem_addr | output | 16 | Word address to memory (memory address register) |
| mem_wdata | output | 16 | Write data to memory (memory data register) |
| mem_we | output | 1 | Memory write enable, held low |
| mem_rdata | input | 16 | Read data, valid one clock after the address |
| phase | output | 4 | Current phase code |
| pc | output | 16 | Program counter |

## Verification
The bench sweeps the add over every destination and source triple, with aliasing cases such as a destination that equals a source and both sources equal. Each add is followed by a jump through the destination, so the stored sum comes out on the program counter. A core that read operands after the write, or that swapped field positions, would jump to the wrong address. The load offset is swept over all 64 values. Offsets with bit 5 set catch a core that sign-extends, because it would read the wrong memory word. The 13 unused opcodes are sent with all operand fields set to ones, and every register is probed afterwards to catch a stray write. Freezes are injected at decode, address evaluation, execute and store to catch a state element that ignores `run`.

// File: rtl/phc_pkg.sv
package phc_pkg;

  typedef enum logic [3:0] {
    PH_F_MAR  = 4'd0,
    PH_F_RD   = 4'd1,
    PH_F_MDR  = 4'd2,
    PH_F_IR   = 4'd3,
    PH_F_PC   = 4'd4,
    PH_DECODE = 4'd5,
    PH_EVAL   = 4'd6,
    PH_OP_RD  = 4'd7,
    PH_OP_LD  = 4'd8,
    PH_EXEC   = 4'd9,
    PH_STORE  = 4'd10
  } phase_e;

  localparam logic [3:0] OPC_ADD  = 4'b0001;
  localparam logic [3:0] OPC_JUMP = 4'b0100;
  localparam logic [3:0] OPC_LDO  = 4'b0110;

endpackage

// File: rtl/phc_regfile.sv
module phc_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [NREG*DW-1:0] word_bus;

  for (genvar g = 0; g < NREG; g++) begin : g_word
    logic [DW-1:0] word_q;
    logic          word_en;

    assign word_en = we && (waddr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= wdata;
      end
    end

    assign word_bus[g*DW +: DW] = word_q;
  end

  assign rdata_a = word_bus[raddr_a*DW +: DW];
  assign rdata_b = word_bus[raddr_b*DW +: DW];

endmodule

// File: rtl/phc_alu.sv
module phc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] sum
);

  always_comb begin
    sum = opnd_a + opnd_b;
  end

endmodule

// File: rtl/phc_ctrl.sv
module phc_ctrl
  import phc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] opcode,
  output phase_e     phase_q
);

  phase_e phase_d;

  always_comb begin
    phase_d = PH_F_MAR;
    unique case (phase_q)
      PH_F_MAR:  phase_d = PH_F_RD;
      PH_F_RD:   phase_d = PH_F_MDR;
      PH_F_MDR:  phase_d = PH_F_IR;
      PH_F_IR:   phase_d = PH_F_PC;
      PH_F_PC:   phase_d = PH_DECODE;
      PH_DECODE: begin
        if (opcode == OPC_LDO) begin
          phase_d = PH_EVAL;
        end else if (opcode == OPC_ADD || opcode == OPC_JUMP) begin
          phase_d = PH_OP_LD;
        end else begin
          phase_d = PH_F_MAR;
        end
      end
      PH_EVAL:   phase_d = PH_OP_RD;
      PH_OP_RD:  phase_d = PH_OP_LD;
      PH_OP_LD:  phase_d = (opcode == OPC_LDO) ? PH_STORE : PH_EXEC;
      PH_EXEC:   phase_d = (opcode == OPC_ADD) ? PH_STORE : PH_F_MAR;
      PH_STORE:  phase_d = PH_F_MAR;
      default:   phase_d = PH_F_MAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_F_MAR;
    end else if (run) begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/phase_core.sv
module phase_core
  import phc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [3:0]    phase,
  output logic [DW-1:0] pc
);

  localparam int AW    = $clog2(NREG);
  localparam int OFF_W = 6;

  phase_e ph;

  logic [DW-1:0] pc_q, pc_d, mar_q, mar_d, mdr_q, ir_q;
  logic [DW-1:0] ta_q, tb_q, res_q;
  logic          pc_en, mar_en, mdr_en, ir_en, opnd_en, res_en;

  logic [3:0]    opcode;
  logic          is_add, is_jump, is_ldo;
  logic [AW-1:0] f_dst, f_src1, f_src2;
  logic [DW-1:0] off_ext;

  logic [DW-1:0] rd_a, rd_b, rf_wdata;
  logic          rf_we;
  logic [DW-1:0] alu_a, alu_b, alu_y;

  // instruction field split
  assign opcode  = ir_q[15:12];
  assign f_dst   = ir_q[11:9];
  assign f_src1  = ir_q[8:6];
  assign f_src2  = ir_q[2:0];
  assign off_ext = {{(DW-OFF_W){1'b0}}, ir_q[OFF_W-1:0]};
  assign is_add  = (opcode == OPC_ADD);
  assign is_jump = (opcode == OPC_JUMP);
  assign is_ldo  = (opcode == OPC_LDO);

  phc_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .opcode  (opcode),
    .phase_q (ph)
  );

  phc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (f_dst),
    .wdata   (rf_wdata),
    .raddr_a (f_src1),
    .raddr_b (f_src2),
    .rdata_a (rd_a),
    .rdata_b (rd_b)
  );

  // one adder: effective address in EVAL, sum in EXEC
  assign alu_a = (ph == PH_EVAL) ? rd_a    : ta_q;
  assign alu_b = (ph == PH_EVAL) ? off_ext : tb_q;

  phc_alu #(.DW(DW)) u_alu (
    .opnd_a (alu_a),
    .opnd_b (alu_b),
    .sum    (alu_y)
  );

  // next-value and enable logic
  always_comb begin
    pc_en    = 1'b0;
    pc_d     = pc_q;
    mar_en   = 1'b0;
    mar_d    = mar_q;
    mdr_en   = 1'b0;
    ir_en    = 1'b0;
    opnd_en  = 1'b0;
    res_en   = 1'b0;
    rf_we    = 1'b0;
    rf_wdata = is_ldo ? mdr_q : res_q;
    if (run) begin
      unique case (ph)
        PH_F_MAR: begin
          mar_en = 1'b1;
          mar_d  = pc_q;
        end
        PH_F_MDR: mdr_en = 1'b1;
        PH_F_IR:  ir_en  = 1'b1;
        PH_F_PC: begin
          pc_en = 1'b1;
          pc_d  = pc_q + DW'(1);
        end
        PH_EVAL: begin
          mar_en = 1'b1;
          mar_d  = alu_y;
        end
        PH_OP_LD: begin
          mdr_en  = is_ldo;
          opnd_en = !is_ldo;
        end
        PH_EXEC: begin
          res_en = is_add;
          pc_en  = is_jump;
          pc_d   = ta_q;
        end
        PH_STORE: rf_we = 1'b1;
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
    end else if (mar_en) begin
      mar_q <= mar_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q <= '0;
    end else if (mdr_en) begin
      mdr_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else if (ir_en) begin
      ir_q <= mdr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_q <= '0;
      tb_q <= '0;
    end else if (opnd_en) begin
      ta_q <= rd_a;
      tb_q <= rd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= alu_y;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = 1'b0;
  assign phase     = ph;
  assign pc        = pc_q;

endmodule

// File: rtl/phc_sva.sv
module phc_sva
  import phc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [3:0]  phase,
  input logic [15:0] pc,
  input logic [15:0] mem_addr,
  input logic [3:0]  opcode
);

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 4'd10);

  // R2
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == 4'd0) |=> (phase == 4'd1 && mem_addr == $past(pc)));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == 4'd4) |=> (phase == 4'd5 && pc == $past(pc) + 16'd1));

  // R4
  add_skip_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == 4'd5 && opcode == OPC_ADD) |=> phase == 4'd8);

  // R5
  load_skip_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == 4'd8 && opcode == OPC_LDO) |=> phase == 4'd10);

  // R6
  jump_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == 4'd9 && opcode == OPC_JUMP) |=> phase == 4'd0);

  // R7
  nop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == 4'd5 && opcode != OPC_ADD && opcode != OPC_LDO
     && opcode != OPC_JUMP) |=> (phase == 4'd0 && $stable(pc)));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(phase) && $stable(pc) && $stable(mem_addr)));

endmodule

bind phase_core phc_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .phase    (phase),
  .pc       (pc),
  .mem_addr (mem_addr),
  .opcode   (ir_q[15:12])
);

// File: tb/sim_phase_core.sv
module sim_phase_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        run;
  logic [15:0] mem_rdata;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [3:0]  phase;
  logic [15:0] pc;

  logic [15:0] cur_instr;
  logic [15:0] mreg [8];
  logic [15:0] mpc;
  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  phase_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .phase     (phase),
    .pc        (pc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] dataf(input logic [15:0] a);
    logic [15:0] p;
    p = a * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  // synchronous memory: instruction word on fetch reads, data pattern otherwise
  always @(posedge clk) begin
    mem_rdata <= (phase == 4'd1) ? cur_instr : dataf(mem_addr);
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > WATCHDOG) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: actual=%0d expected<=%0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_add(input logic [2:0] d, input logic [2:0] a,
                                          input logic [2:0] b);
    return {4'b0001, d, a, 3'b000, b};
  endfunction

  function automatic logic [15:0] enc_ld(input logic [2:0] d, input logic [2:0] b,
                                         input logic [5:0] off);
    return {4'b0110, d, b, off};
  endfunction

  function automatic logic [15:0] enc_jmp(input logic [2:0] r);
    return {4'b0100, 3'b000, r, 6'b000000};
  endfunction

  // run one instruction from phase 0 to the next phase 0, optionally freezing at stall_ph
  task automatic run_instr(input logic [15:0] w, input logic [3:0] stall_ph,
                           input string tag);
    logic [3:0]  exp_seq [12];
    int          n;
    int          k;
    bit          seq_ok;
    bit          stalled;
    bit          st_ok;
    logic [3:0]  op;
    logic [2:0]  d, s1, s2;
    logic [15:0] ea;
    logic [3:0]  sp;
    logic [15:0] spc, sa;
    op = w[15:12];
    d  = w[11:9];
    s1 = w[8:6];
    s2 = w[2:0];
    ea = mreg[s1] + {10'b0, w[5:0]};
    for (int j = 0; j < 12; j++) exp_seq[j] = 4'd0;
    for (int j = 0; j < 6; j++) exp_seq[j] = 4'(j);
    n = 6;
    case (op)
      4'b0001: begin exp_seq[6] = 4'd8; exp_seq[7] = 4'd9; exp_seq[8] = 4'd10; n = 9; end
      4'b0110: begin
        exp_seq[6] = 4'd6; exp_seq[7] = 4'd7; exp_seq[8] = 4'd8; exp_seq[9] = 4'd10; n = 10;
      end
      4'b0100: begin exp_seq[6] = 4'd8; exp_seq[7] = 4'd9; n = 8; end
      default: n = 6;
    endcase
    cur_instr = w;
    k = 0;
    seq_ok = 1'b1;
    stalled = 1'b0;
    forever begin
      if (k < n) begin
        if (phase != exp_seq[k]) seq_ok = 1'b0;
      end else begin
        seq_ok = 1'b0;
      end
      if (phase == 4'd1) chk(mem_addr == mpc, "R2 fetch address", mem_addr, mpc);
      if (op == 4'b0110 && phase == 4'd7)
        chk(mem_addr == ea, "R5 load address", mem_addr, ea);
      if (phase == stall_ph && !stalled) begin
        stalled = 1'b1;
        sp  = phase;
        spc = pc;
        sa  = mem_addr;
        st_ok = 1'b1;
        run = 1'b0;
        repeat (3) begin
          @(negedge clk);
          if (phase != sp || pc != spc || mem_addr != sa) st_ok = 1'b0;
        end
        chk(st_ok, "R8 halt freeze", {12'b0, phase}, {12'b0, sp});
        run = 1'b1;
      end
      @(negedge clk);
      k = k + 1;
      if (phase == 4'd0 || k >= 16) break;
    end
    chk(seq_ok && k == n, {tag, " phase sequence (R3)"}, 16'(k), 16'(n));
    case (op)
      4'b0001: begin mreg[d] = mreg[s1] + mreg[s2]; mpc = mpc + 16'd1; end
      4'b0110: begin mreg[d] = dataf(ea); mpc = mpc + 16'd1; end
      4'b0100: mpc = mreg[s1];
      default: mpc = mpc + 16'd1;
    endcase
    chk(pc == mpc, {tag, " next pc"}, pc, mpc);
  endtask

  task automatic probe(input logic [2:0] r, input string tag);
    run_instr(enc_jmp(r), 4'hF, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    run = 1'b1;
    cur_instr = 16'h0000;
    mpc = 16'h0000;
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(phase == 4'd0, "R1 reset phase", {12'b0, phase}, 16'h0000);
    chk(pc == 16'h0000, "R1 reset pc", pc, 16'h0000);
    chk(mem_we == 1'b0, "R1 reset write enable", {15'b0, mem_we}, 16'h0000);
    for (int r = 0; r < 8; r++) probe(3'(r), "R1 register cleared via R6 jump");

    // R5 fill registers through loads
    for (int i = 1; i < 8; i++) run_instr(enc_ld(3'(i), 3'd0, 6'(9 * i)), 4'hF, "R5 load");
    run_instr(enc_ld(3'd0, 3'd7, 6'd63), 4'hF, "R5 load offset 63");
    for (int r = 0; r < 8; r++) probe(3'(r), "R5 loaded value via R6 jump");

    // R4 exhaustive add field sweep, result observed through R6 jump
    for (int d = 0; d < 8; d++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          run_instr(enc_add(3'(d), 3'(a), 3'(b)), 4'hF, "R4 add");
          probe(3'(d), "R4 sum via R6 jump");
        end

    // R5 offset sweep, includes offsets with bit 5 set (zero extension)
    for (int off = 0; off < 64; off++) begin
      run_instr(enc_ld(3'(off % 8), 3'((off * 3) % 8), 6'(off)), 4'hF, "R5 load offset");
      probe(3'(off % 8), "R5 loaded word via R6 jump");
    end

    // R7 unused opcodes with all fields set
    for (int op = 0; op < 16; op++) begin
      if (op != 1 && op != 4 && op != 6)
        run_instr({4'(op), 12'hFFF}, 4'hF, "R7 unused opcode");
    end
    for (int r = 0; r < 8; r++) probe(3'(r), "R7 registers unchanged");

    // R8 freezes at several phases
    run_instr(enc_add(3'd2, 3'd3, 3'd4), 4'd0, "R8 add frozen at fetch start");
    run_instr(enc_add(3'd5, 3'd5, 3'd2), 4'd5, "R8 add frozen at decode");
    run_instr(enc_add(3'd6, 3'd1, 3'd5), 4'd9, "R8 add frozen at execute");
    run_instr(enc_add(3'd1, 3'd6, 3'd6), 4'd10, "R8 add frozen at store");
    run_instr(enc_ld(3'd3, 3'd1, 6'd33), 4'd6, "R8 load frozen at address evaluation");
    run_instr(enc_ld(3'd4, 3'd2, 6'd7), 4'd10, "R8 load frozen at store");
    run_instr(enc_jmp(3'd5), 4'd9, "R8 jump frozen at execute");
    run_instr(16'hF123, 4'd5, "R8 no-op frozen at decode");
    for (int r = 0; r < 8; r++) probe(3'(r), "R8 registers after freezes");

    summary();
    $finish;
  end

endmodule